// File: doc/BRIEF.md
# Phase-Stepped Programmable Clock Divider

The block derives one output clock from an oscillator that offers eight equally spaced phase taps. The design clock `clk` advances one tap (45 degrees of the oscillator period) per cycle, so one oscillator period is eight `clk` cycles. A tap reference counter runs freely from reset. An integer divider turns the oscillator into the output clock. Software programs it through a 32-bit control word that holds a divide count and a phase-step request count.

Software loads the step count, and hardware uses it up one step at a time. Each step delays every later output edge by one tap. It does this by stretching the last low cycle of an output period by one `clk` cycle. The step field counts down as the steps are applied, so software can poll it until it reads zero. A divider-reset input and an align input clear the accumulated phase, so the next rising edge falls on tap 0. The control fields survive a warm reset and return to their defaults only on a cold reset.

Top module: `phstep_clkdiv`

## Requirements
- R1: After cold reset the divide count is 1 and the step count is 0. A read returns 32'h0000_0001, `busy` is low and `clk_out` is low.
- R2: Control word layout: divide count in bits 8:0, step count in bits 20:9, bits 31:21 read as zero. `rd_data` shows the fields as they stood before the edge at which `rd_en` is sampled, and it holds that value until the next read.
- R3: With divide value N = count+1, the output period is 8·N cycles. For N ≥ 2 the output is high for 8·floor(N/2) cycles at the start of the period and low for the rest. For N = 1 it is high 4 and low 4, which matches the selected tap.
- R4: A write always updates the divide count. It updates the step count only if that field reads zero in the write cycle; otherwise the written step value is ignored.
- R5: Each applied step lowers the step count by one. `busy` is high exactly while the step count is nonzero.
- R6: A step is applied only at the last low cycle of a period, and at most one per period. That period becomes 8·N+1 cycles long, and the output stays low through the extra cycle.
- R7: While `div_rst` is high the output is low. After it falls, the output starts a fresh period whose first (high) cycle falls on tap 0. The accumulated phase is cleared and pending steps are kept.
- R8: A one-cycle `align` pulse clears the accumulated phase the same way: the next rising edge falls on tap 0.
- R9: A new divide count takes effect at the next period boundary. The period in progress keeps its length.
- R10: A warm reset restarts the divider and the tap reference but leaves both control fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tap-rate clock, eight cycles per oscillator period |
| rst_cold_n | input | 1 | Active-low cold reset, resets everything including the control fields |
| rst_warm_n | input | 1 | Active-low warm reset, resets the divider and tap reference only |
| div_rst | input | 1 | Divider reset: holds the output low and clears the accumulated phase |
| align | input | 1 | Phase-align pulse: clears the accumulated phase and restarts on tap 0 |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_en | input | 1 | Control word read strobe |
| rd_data | output | 32 | Registered read data |
| clk_out | output | 1 | Divided, phase-stepped output clock |
| busy | output | 1 | High while phase steps are still pending |

## Verification
Two events can land on the same edge: hardware applies a step and lowers the step count, while software writes a new step value. The write is only legal once the field reaches zero. A decrement from one to zero in that same cycle must not let the write through. The bench provokes this with a long run that uses the shortest divide value, so steps fall every nine cycles, and writes a small step value on every cycle. A behavioural model compares `clk_out`, `busy` and `rd_data` on every cycle. The bench also counts how often a write coincides with a step and requires that this happened.

// File: rtl/phstep_clkdiv_pkg.sv
package phstep_clkdiv_pkg;

   // divider sequencing: waiting for tap 0, running a period, or in the inserted slip cycle
   typedef enum logic [1:0] {
      DIV_SYNC  = 2'd0,
      DIV_RUN   = 2'd1,
      DIV_SLIP  = 2'd2
   } div_state_t;

endpackage

// File: rtl/phstep_tapref.sv
module phstep_tapref #(
   parameter int unsigned TAPS = 8,
   localparam int unsigned TAP_W = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TAP_W-1:0] tap
);

   initial begin
      if (TAPS < 2 || (TAPS & (TAPS - 1)) != 0)
         $error("TAPS must be a power of two not below 2");
   end

   generate
      if (TAPS == (1 << TAP_W)) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap <= '0;
            else        tap <= tap + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          tap <= '0;
            else if (tap == TAP_W'(TAPS - 1))    tap <= '0;
            else                                 tap <= tap + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/phstep_regs.sv
module phstep_regs #(
   parameter int unsigned CNT_W   = 9,
   parameter int unsigned PH_W    = 12,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned CNT_RST = 1,
   localparam int unsigned USED_W = CNT_W + PH_W
) (
   input  logic             clk,
   input  logic             rst_cold_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_en,
   output logic [REG_W-1:0] rd_data,
   input  logic             step_ack,
   output logic [CNT_W-1:0] count_q,
   output logic [PH_W-1:0]  phase_q,
   output logic             busy
);

   logic [REG_W-1:0] word;

   initial begin
      if (REG_W < USED_W) $error("REG_W too narrow for both fields");
      if (CNT_RST >= (1 << CNT_W)) $error("CNT_RST does not fit CNT_W");
   end

   generate
      if (REG_W > USED_W) begin : g_pad
         assign word = {{(REG_W - USED_W){1'b0}}, phase_q, count_q};
      end else begin : g_exact
         assign word = {phase_q, count_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_cold_n) begin
      if (!rst_cold_n) begin
         count_q <= CNT_W'(CNT_RST);
         phase_q <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en) count_q <= wr_data[CNT_W-1:0];
         if (wr_en && phase_q == '0)
            phase_q <= wr_data[USED_W-1:CNT_W];
         else if (step_ack)
            phase_q <= phase_q - 1'b1;
         if (rd_en) rd_data <= word;
      end
   end

   assign busy = (phase_q != '0);

   AST_STEP_GUARD: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (wr_en && phase_q != '0) |=> phase_q == $past(phase_q) - PH_W'($past(step_ack))); // R4
   AST_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_cold_n)
      step_ack |-> phase_q != '0); // R5
   AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_cold_n)
      step_ack |=> phase_q == $past(phase_q) - 1'b1); // R5

endmodule

// File: rtl/phstep_core.sv
module phstep_core
   import phstep_clkdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 9,
   parameter int unsigned TAPS  = 8,
   localparam int unsigned TAP_W = $clog2(TAPS),
   localparam int unsigned N_W   = CNT_W + 1,
   localparam int unsigned POS_W = TAP_W + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_rst,
   input  logic             align,
   input  logic [TAP_W-1:0] tap,
   input  logic [CNT_W-1:0] count,
   input  logic             step_req,
   output logic             step_ack,
   output logic             clk_out
);

   div_state_t       st;
   logic [POS_W-1:0] pos, last_q, hi_q;
   logic [TAP_W-1:0] offset;
   logic [N_W-1:0]   n_new;
   logic [POS_W:0]   len_full, hi_full;
   logic [POS_W-1:0] last_new, hi_new;
   logic             restart, at_end;

   initial begin
      if (CNT_W < 1) $error("CNT_W must be at least 1");
   end

   // period geometry for the count now in the register
   always_comb begin
      n_new    = N_W'(count) + 1'b1;
      len_full = (POS_W + 1)'(n_new) << TAP_W;
      if (n_new == N_W'(1))
         hi_full = (POS_W + 1)'(TAPS / 2);
      else
         hi_full = (POS_W + 1)'(n_new >> 1) << TAP_W;
      last_new = POS_W'(len_full - 1'b1);
      hi_new   = POS_W'(hi_full);
   end

   assign restart  = div_rst | align;
   assign at_end   = (st == DIV_RUN) && (pos == last_q);
   assign step_ack = at_end && step_req && !restart;
   assign clk_out  = (st == DIV_RUN) && (pos < hi_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= DIV_SYNC;
         pos    <= '0;
         last_q <= '0;
         hi_q   <= '0;
         offset <= '0;
      end else if (restart) begin
         st     <= DIV_SYNC;
         pos    <= '0;
         offset <= '0;
      end else begin
         unique case (st)
            DIV_SYNC: begin
               if (tap == TAP_W'(TAPS - 1)) begin
                  st     <= DIV_RUN;
                  pos    <= '0;
                  last_q <= last_new;
                  hi_q   <= hi_new;
               end
            end
            DIV_RUN: begin
               if (pos == last_q) begin
                  if (step_req) begin
                     st     <= DIV_SLIP;
                     offset <= offset + 1'b1;
                  end else begin
                     pos    <= '0;
                     last_q <= last_new;
                     hi_q   <= hi_new;
                  end
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            DIV_SLIP: begin
               st     <= DIV_RUN;
               pos    <= '0;
               last_q <= last_new;
               hi_q   <= hi_new;
            end
            default: st <= DIV_SYNC;
         endcase
      end
   end

   AST_SLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      step_ack |-> !clk_out); // R6
   AST_ONE_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
      step_ack |=> !step_ack && !clk_out); // R6
   AST_EDGE_ON_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == DIV_RUN && pos == '0) |-> tap == offset); // R7
   AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      div_rst |=> !clk_out); // R7
   AST_ALIGN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      align |=> !clk_out); // R8

endmodule

// File: rtl/phstep_clkdiv.sv
module phstep_clkdiv #(
   parameter int unsigned CNT_W   = 9,
   parameter int unsigned PH_W    = 12,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned TAPS    = 8,
   parameter int unsigned CNT_RST = 1
) (
   input  logic             clk,
   input  logic             rst_cold_n,
   input  logic             rst_warm_n,
   input  logic             div_rst,
   input  logic             align,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_en,
   output logic [REG_W-1:0] rd_data,
   output logic             clk_out,
   output logic             busy
);

   localparam int unsigned TAP_W = $clog2(TAPS);

   logic             core_rst_n;
   logic [TAP_W-1:0] tap;
   logic [CNT_W-1:0] count_q;
   logic [PH_W-1:0]  phase_q;
   logic             step_ack;

   assign core_rst_n = rst_cold_n & rst_warm_n;

   phstep_tapref #(.TAPS(TAPS)) u_tapref (
      .clk   (clk),
      .rst_n (core_rst_n),
      .tap   (tap)
   );

   phstep_regs #(
      .CNT_W   (CNT_W),
      .PH_W    (PH_W),
      .REG_W   (REG_W),
      .CNT_RST (CNT_RST)
   ) u_regs (
      .clk        (clk),
      .rst_cold_n (rst_cold_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .rd_data    (rd_data),
      .step_ack   (step_ack),
      .count_q    (count_q),
      .phase_q    (phase_q),
      .busy       (busy)
   );

   phstep_core #(.CNT_W(CNT_W), .TAPS(TAPS)) u_core (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .div_rst  (div_rst),
      .align    (align),
      .tap      (tap),
      .count    (count_q),
      .step_req (busy),
      .step_ack (step_ack),
      .clk_out  (clk_out)
   );

   AST_COLD_FIELDS: assert property (@(posedge clk)
      !rst_cold_n |=> count_q == CNT_W'(CNT_RST) && phase_q == '0); // R1
   AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (!rst_warm_n && !wr_en) |=> count_q == $past(count_q) && phase_q == $past(phase_q)); // R10

endmodule

// File: tb/phstep_clkdiv_test.sv
module phstep_clkdiv_test;

   localparam int CLK_P = 10;
   localparam int Q = CLK_P / 4;

   logic        clk = 1'b0;
   logic        rst_cold_n = 1'b0, rst_warm_n = 1'b0;
   logic        div_rst = 1'b0, align = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        clk_out, busy;

   int total = 0, bad = 0, coll = 0;
   bit done = 0;

   // behavioural model state
   int m_cnt, m_ph, m_tk, m_pos, m_n;
   bit m_run, m_slip;
   logic [31:0] m_rd;

   always #(CLK_P/2) clk = ~clk;

   phstep_clkdiv uut (
      .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
      .div_rst(div_rst), .align(align), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .clk_out(clk_out), .busy(busy)
   );

   function automatic int hi_of(int n);
      return (n == 1) ? 4 : 8 * (n / 2);
   endfunction

   function automatic bit m_out();
      return m_run && !m_slip && (m_pos < hi_of(m_n));
   endfunction

   always @(posedge clk or negedge rst_cold_n or negedge rst_warm_n) begin
      if (!rst_cold_n) begin
         m_cnt = 1; m_ph = 0; m_rd = '0; m_tk = 0;
         m_run = 0; m_pos = 0; m_slip = 0; m_n = 1;
      end else if (!rst_warm_n) begin
         m_tk = 0; m_run = 0; m_pos = 0; m_slip = 0;
      end else begin
         bit ack;
         int old_cnt, old_tk;
         ack = m_run && !m_slip && (m_pos == 8 * m_n - 1) && (m_ph != 0) && !div_rst && !align;
         if (ack && wr_en) coll++;
         if (rd_en) m_rd = 32'((m_ph << 9) | m_cnt);
         old_cnt = m_cnt;
         old_tk  = m_tk;
         if (wr_en && m_ph == 0) m_ph = int'(wr_data[20:9]);
         else if (ack)           m_ph = m_ph - 1;
         if (wr_en) m_cnt = int'(wr_data[8:0]);
         m_tk = (m_tk + 1) % 8;
         if (div_rst || align) begin
            m_run = 0; m_pos = 0; m_slip = 0;
         end else if (!m_run) begin
            if (old_tk == 7) begin m_run = 1; m_pos = 0; m_n = old_cnt + 1; end
         end else if (m_slip) begin
            m_slip = 0; m_pos = 0; m_n = old_cnt + 1;
         end else if (m_pos == 8 * m_n - 1) begin
            if (ack) m_slip = 1;
            else begin m_pos = 0; m_n = old_cnt + 1; end
         end else begin
            m_pos++;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(posedge clk);
      #(Q);
      chk("R6 cycle clk_out", {31'd0, clk_out}, {31'd0, m_out()});
      chk("R5 cycle busy", {31'd0, busy}, {31'd0, m_ph != 0});
      chk("R2 cycle rd_data", rd_data, m_rd);
   end

   task automatic nxt();
      @(posedge clk);
      #(Q);
   endtask

   task automatic rise_wait();
      bit prev;
      int guard = 0;
      prev = clk_out;
      forever begin
         nxt();
         if (!prev && clk_out) break;
         prev = clk_out;
         guard++;
         if (guard > 6000) begin
            chk("R3 rise timeout", 32'd0, 32'd1);
            break;
         end
      end
   endtask

   // from a rising sample, measure high cycles and the period up to the next rise
   task automatic measure(output int hi, output int per);
      bit prev;
      hi = 1; per = 1; prev = 1'b1;
      forever begin
         nxt();
         if (!prev && clk_out) break;
         prev = clk_out;
         per++;
         if (clk_out) hi++;
         if (per > 6000) break;
      end
   endtask

   task automatic wr(logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, keep;
      int hi, per;
      repeat (3) @(negedge clk);
      rst_cold_n = 1'b1; rst_warm_n = 1'b1;

      // R1 reset state
      chk("R1 clk_out after reset", {31'd0, clk_out}, 32'd0);
      chk("R1 busy after reset", {31'd0, busy}, 32'd0);
      rd(v);
      chk("R1 reset word", v, 32'h0000_0001);

      // R3 default N=2
      rise_wait();
      measure(hi, per);
      chk("R3 N=2 high", 32'(hi), 32'd8);
      chk("R3 N=2 period", 32'(per), 32'd16);

      // hold divider, program fields
      @(negedge clk); div_rst = 1'b1;
      wr(32'hFFE0_0000 | (32'd5 << 9) | 32'd3);
      rd(v);
      chk("R2 layout, reserved zero", v, 32'h0000_0A03);
      chk("R5 busy while pending", {31'd0, busy}, 32'd1);
      wr((32'd7 << 9) | 32'd2);
      rd(v);
      chk("R4 step write ignored while nonzero", v, 32'h0000_0A02);
      wr(32'd3);
      chk("R7 low during divider reset", {31'd0, clk_out}, 32'd0);

      // release: first edge on tap 0, five slipped periods then plain ones
      @(negedge clk); div_rst = 1'b0;
      rise_wait();
      chk("R7 first edge on tap 0", 32'(m_tk), 32'd0);
      for (int i = 0; i < 5; i++) begin
         measure(hi, per);
         chk("R6 slipped period", 32'(per), 32'd33);
         chk("R3 N=4 high", 32'(hi), 32'd16);
      end
      measure(hi, per);
      chk("R3 N=4 period", 32'(per), 32'd32);
      chk("R5 busy cleared", {31'd0, busy}, 32'd0);
      rd(v);
      chk("R5 steps drained", v, 32'h0000_0003);

      // R8 align: edge returns to tap 0
      @(negedge clk); align = 1'b1;
      @(negedge clk); align = 1'b0;
      rise_wait();
      chk("R8 edge on tap 0 after align", 32'(m_tk), 32'd0);

      // R9 count change mid-period
      repeat (3) nxt();
      wr(32'd0);
      rise_wait();
      measure(hi, per);
      chk("R9 N=1 high", 32'(hi), 32'd4);
      chk("R9 N=1 period", 32'(per), 32'd8);
      wr(32'd4);
      rise_wait();
      measure(hi, per);
      chk("R3 odd N=5 high", 32'(hi), 32'd16);
      chk("R3 odd N=5 period", 32'(per), 32'd40);

      // collision: writes every cycle while steps fall every nine cycles
      wr(32'd0);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_data = ($urandom_range(0, 3) << 9);
      end
      @(negedge clk); wr_en = 1'b0;
      total++;
      if (coll == 0) begin
         bad++;
         $display("FAIL R4 no write met a step actual=0 expected>0");
      end

      // R10 warm reset keeps fields
      wr((32'd2 << 9) | 32'd6);
      @(negedge clk); div_rst = 1'b1;
      wr(32'd6);
      rd(keep);
      @(negedge clk); rst_warm_n = 1'b0;
      @(negedge clk);
      chk("R10 low in warm reset", {31'd0, clk_out}, 32'd0);
      rst_warm_n = 1'b1;
      rd(v);
      chk("R10 fields kept", v, keep);
      @(negedge clk); div_rst = 1'b0;
      rise_wait();
      chk("R10 restart on tap 0", 32'(m_tk), 32'd0);

      // cold reset restores defaults
      @(negedge clk); rst_cold_n = 1'b0;
      @(negedge clk); rst_cold_n = 1'b1;
      rd(v);
      chk("R1 cold reset word", v, 32'h0000_0001);

      repeat (4) nxt();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule